// File: doc/BRIEF.md
# Character and Nametable Bank Selector

This block sits on the video side of a cartridge-style memory mapper. It turns a set of CPU-written bank registers into a 1 KB page number for each of the eight pattern-table slots of the 8 KB character window. It also decides how the four nametable quadrants are served: from hard-wired video RAM mirroring, or from character ROM pages.

Each character bank is 16 bits wide. Its low byte and its high byte are written at separate addresses. A mode register selects the page granularity: one 8 KB page, two 4 KB pages, four 2 KB pages or eight 1 KB pages. The outputs follow the registers combinationally, so a write shows on the outputs from the clock edge that captures it. ROM-based nametables can be requested, but the request is overridden whenever any nametable entry maps a quadrant onto itself.

Top module: `vidBankMap`

## Requirements
- R1: On a write (wrEn high at a rising clock edge), address bits 15:12 and 2:0 are decoded and all other address bits are ignored. Pattern 0x9 with bits 2:0 = i loads the low byte of character bank i. Pattern 0xA with bits 2:0 = i loads the high byte. Bank i is (high << 8) | low.
- R2: After reset, low byte i holds i and every high byte holds 0. The size mode is 0, the mirror type is 0, the ROM-nametable request is clear, and every nametable byte is 0. slotPages therefore reads 0..7 for slots 0..7.
- R3: In size mode 0, slot k (field [k*19 +: 19] of slotPages) shows bank0*8 + k.
- R4: In size mode 1, slots 0..3 show bank0*4 + k and slots 4..7 show bank4*4 + (k-4).
- R5: In size mode 2, slot k shows bank(k with bit 0 cleared)*2 + (k mod 2).
- R6: In size mode 3, slot k shows bank k.
- R7: A write to pattern 0xD with bits 2:0 = 0 sets the size mode from data bits 4:3 and the ROM-nametable request from data bit 5. A write to 0xD with bits 2:0 = 1 sets the mirror type from data bits 1:0. ntMirror reads 0 (vertical) for type 0, 1 (horizontal) for type 1, and 2 (single-screen lower) for types 2 and 3.
- R8: A write to pattern 0xB with bit 2 = 0 loads the low byte of nametable entry bits 1:0. With bit 2 = 1 it loads the high byte. ntPages field [j*16 +: 16] shows (high << 8) | low of entry j.
- R9: ntUseRom is 1 only when the ROM request is set and no entry j has high byte 0 and low byte equal to j. It is re-evaluated on every register change.
- R10: Writes to any other decoded pattern (e.g. 0x8000, 0xC005, 0xD002, 0xD003, 0xE000), and any cycle with wrEn low, leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| slotPages | output | 152 | Eight 19-bit 1 KB page numbers, slot k at [k*19 +: 19] |
| ntPages | output | 64 | Four 16-bit nametable banks, entry j at [j*16 +: 16] |
| ntUseRom | output | 1 | Nametables come from ROM pages |
| ntMirror | output | 2 | 0 vertical, 1 horizontal, 2 single-screen lower |

## Verification
On every cycle, the assertions check four things. The decoder raises at most one strobe, and none while wrEn is low. The outputs hold steady when no strobe is raised. The slots are contiguous in 8 KB mode and paired in 2 KB mode. ROM nametables are never chosen without a request. Only the bench scenarios can show that the right byte of the right bank is loaded through aliased addresses, and that the exact page values are correct in all four size modes. The scenarios also cover the mirror-type encoding and cancellation of the ROM request by each nametable entry in turn.

// File: rtl/vidBankPkg.sv
package vidBankPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic chrLoWe;
    logic chrHiWe;
    logic ntLoWe;
    logic ntHiWe;
    logic modeWe;
    logic mirWe;
    logic [2:0] idx;
    logic [BYTE_W-1:0] data;
  } bankStrobe_t;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_SINGLE = 2'd2
  } mirSel_e;
endpackage

// File: rtl/vidBankCtrl.sv
module vidBankCtrl
  import vidBankPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output bankStrobe_t       strb
);
  logic [3:0] page;
  logic [2:0] low;

  assign page = wrAddr[ADDR_W-1 -: 4];
  assign low  = wrAddr[2:0];

  always_comb begin
    strb      = '0;
    strb.idx  = low;
    strb.data = wrData;
    if (wrEn) begin
      unique case (page)
        4'h9: strb.chrLoWe = 1'b1;
        4'hA: strb.chrHiWe = 1'b1;
        4'hB: begin
          strb.ntLoWe = ~low[2];
          strb.ntHiWe = low[2];
        end
        4'hD: begin
          strb.modeWe = (low == 3'd0);
          strb.mirWe  = (low == 3'd1);
        end
        default: ;
      endcase
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.chrLoWe, strb.chrHiWe, strb.ntLoWe, strb.ntHiWe, strb.modeWe, strb.mirWe}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.chrLoWe || strb.chrHiWe || strb.ntLoWe || strb.ntHiWe || strb.modeWe || strb.mirWe));
endmodule

// File: rtl/vidBankPath.sv
module vidBankPath
  import vidBankPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_NT    = 4
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  bankStrobe_t                                strb,
  output logic [NUM_SLOTS*(2*BYTE_W+$clog2(NUM_SLOTS))-1:0] slotPages,
  output logic [NUM_NT*2*BYTE_W-1:0]                 ntPages,
  output logic                                       ntUseRom,
  output logic [1:0]                                 ntMirror
);
  localparam int BANK_W    = 2 * BYTE_W;
  localparam int SLOT_BITS = $clog2(NUM_SLOTS);
  localparam int NT_BITS   = $clog2(NUM_NT);
  localparam int PAGE_W    = BANK_W + SLOT_BITS;

  logic [BYTE_W-1:0] chrLo [NUM_SLOTS];
  logic [BYTE_W-1:0] chrHi [NUM_SLOTS];
  logic [BYTE_W-1:0] ntLo  [NUM_NT];
  logic [BYTE_W-1:0] ntHi  [NUM_NT];
  logic [1:0]        chrSize;
  logic              romReq;
  logic [1:0]        mirType;
  logic [BANK_W-1:0] bankVal [NUM_SLOTS];
  logic [NUM_NT-1:0] idHit;
  logic              anyWe;

  assign anyWe = strb.chrLoWe | strb.chrHiWe | strb.ntLoWe | strb.ntHiWe | strb.modeWe | strb.mirWe;

  // Character register files
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gChr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chrLo[g] <= BYTE_W'(g);
        chrHi[g] <= '0;
      end else begin
        if (strb.chrLoWe && strb.idx == SLOT_BITS'(g)) chrLo[g] <= strb.data;
        if (strb.chrHiWe && strb.idx == SLOT_BITS'(g)) chrHi[g] <= strb.data;
      end
    end
    assign bankVal[g] = {chrHi[g], chrLo[g]};
  end

  // Nametable register files and identity detection
  for (genvar j = 0; j < NUM_NT; j++) begin : gNt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ntLo[j] <= '0;
        ntHi[j] <= '0;
      end else begin
        if (strb.ntLoWe && strb.idx[NT_BITS-1:0] == NT_BITS'(j)) ntLo[j] <= strb.data;
        if (strb.ntHiWe && strb.idx[NT_BITS-1:0] == NT_BITS'(j)) ntHi[j] <= strb.data;
      end
    end
    assign idHit[j] = (ntHi[j] == '0) && (ntLo[j] == BYTE_W'(j));
    assign ntPages[j*BANK_W +: BANK_W] = {ntHi[j], ntLo[j]};
  end

  // Mode and mirror controls
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chrSize <= 2'd0;
      romReq  <= 1'b0;
      mirType <= 2'd0;
    end else begin
      if (strb.modeWe) begin
        chrSize <= strb.data[4:3];
        romReq  <= strb.data[5];
      end
      if (strb.mirWe) mirType <= strb.data[1:0];
    end
  end

  assign ntUseRom = romReq && !(|idHit);

  always_comb begin
    unique case (mirType)
      2'd0:    ntMirror = MIR_VERT;
      2'd1:    ntMirror = MIR_HORZ;
      default: ntMirror = MIR_SINGLE;
    endcase
  end

  // Page number per slot: a bank covers 2^sh slots
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gSlot
    logic [SLOT_BITS-1:0] baseIdx;
    logic [SLOT_BITS-1:0] offs;
    int                   sh;
    always_comb begin
      sh      = SLOT_BITS - int'(chrSize);
      if (sh < 0) sh = 0;
      baseIdx = SLOT_BITS'((k >> sh) << sh);
      offs    = SLOT_BITS'(k % (1 << sh));
      slotPages[k*PAGE_W +: PAGE_W] = (PAGE_W'(bankVal[baseIdx]) << sh) | PAGE_W'(offs);
    end

    if (k > 0) begin : gContig
      p_contig_r3: assert property (@(posedge clk) disable iff (!rstN)
        (chrSize == 2'd0) |-> slotPages[k*PAGE_W +: PAGE_W] == slotPages[0 +: PAGE_W] + PAGE_W'(k));
    end
    if (k % 2 == 1) begin : gPair
      p_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
        (chrSize == 2'd2) |-> slotPages[k*PAGE_W +: PAGE_W] == slotPages[(k-1)*PAGE_W +: PAGE_W] + PAGE_W'(1));
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyWe |=> ($stable(slotPages) && $stable(ntPages) && $stable(ntUseRom) && $stable(ntMirror)));

  p_rom_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    ntUseRom |-> romReq);
endmodule

// File: rtl/vidBankMap.sv
module vidBankMap
  import vidBankPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_SLOTS = 8,
  parameter int NUM_NT    = 4
) (
  input  logic                                               clk,
  input  logic                                               rstN,
  input  logic                                               wrEn,
  input  logic [ADDR_W-1:0]                                  wrAddr,
  input  logic [7:0]                                         wrData,
  output logic [NUM_SLOTS*(16+$clog2(NUM_SLOTS))-1:0]        slotPages,
  output logic [NUM_NT*16-1:0]                               ntPages,
  output logic                                               ntUseRom,
  output logic [1:0]                                         ntMirror
);
  bankStrobe_t strb;

  vidBankCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  vidBankPath #(.NUM_SLOTS(NUM_SLOTS), .NUM_NT(NUM_NT)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .slotPages(slotPages),
    .ntPages(ntPages), .ntUseRom(ntUseRom), .ntMirror(ntMirror)
  );
endmodule

// File: tb/vidBankMap_bench.sv
module vidBankMap_bench;
  localparam int PW = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [8*PW-1:0] slotPages;
  logic [63:0] ntPages;
  logic ntUseRom;
  logic [1:0] ntMirror;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int mLo[8], mHi[8], nLo[4], nHi[4];
  int mSize, mReq, mMir;

  always #4 clk = ~clk;

  vidBankMap u_vidBankMap (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slotPages(slotPages), .ntPages(ntPages), .ntUseRom(ntUseRom), .ntMirror(ntMirror)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // model update from the requirement text
  task automatic modelWrite(int a, int d);
    int pg = (a >> 12) & 15;
    int lo = a & 7;
    if (pg == 9) mLo[lo] = d;
    else if (pg == 10) mHi[lo] = d;
    else if (pg == 11) begin
      if (lo < 4) nLo[lo] = d; else nHi[lo-4] = d;
    end else if (pg == 13 && lo == 0) begin
      mSize = (d >> 3) & 3; mReq = (d >> 5) & 1;
    end else if (pg == 13 && lo == 1) mMir = d & 3;
  endtask

  task automatic doWrite(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic chkSlots(string req);
    for (int k = 0; k < 8; k++) begin
      int pp = 8 >> mSize;
      int base = (k / pp) * pp;
      longint exp = longint'(mHi[base] * 256 + mLo[base]) * pp + (k % pp);
      chk(req, $sformatf("slot%0d size%0d", k, mSize), longint'(slotPages[k*PW +: PW]), exp);
    end
  endtask

  task automatic chkNt(string req);
    int useExp = mReq;
    for (int j = 0; j < 4; j++) begin
      chk(req, $sformatf("ntPage%0d", j), longint'(ntPages[j*16 +: 16]), nHi[j] * 256 + nLo[j]);
      if (nHi[j] == 0 && nLo[j] == j) useExp = 0;
    end
    chk(req, "ntUseRom", longint'(ntUseRom), useExp);
    chk(req, "ntMirror", longint'(ntMirror), (mMir == 0) ? 0 : (mMir == 1) ? 1 : 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mLo[i] = i; mHi[i] = 0; end
    for (int j = 0; j < 4; j++) begin nLo[j] = 0; nHi[j] = 0; end
    mSize = 0; mReq = 0; mMir = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chkSlots("R2");
    chkNt("R2");

    // R1, R3..R6: bank patterns through aliased addresses, every size mode
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        doWrite(16'h9FF8 | i, (p * 37 + i * 29 + 5) & 255);
        doWrite(16'hA7F0 | i, (p == 3) ? 255 : ((p * 11 + i * 3) & 255));
      end
      for (int s = 0; s < 4; s++) begin
        doWrite(16'hD000, s << 3);
        case (s)
          0: chkSlots("R3");
          1: chkSlots("R4");
          2: chkSlots("R5");
          default: chkSlots("R6");
        endcase
      end
      chkSlots("R1");
    end

    // R7 mirror encoding, upper data bits ignored
    for (int m = 0; m < 4; m++) begin
      doWrite(16'hD001, 8'hFC | m);
      chkNt("R7");
    end

    // R8 nametable banks, non-identity values
    for (int j = 0; j < 4; j++) begin
      doWrite(16'hB000 | j, 8'h40 + j * 3);
      doWrite(16'hB004 | j, 8'h10 + j);
      chkNt("R8");
    end

    // R9 ROM request and identity cancellation per entry
    doWrite(16'hD000, 8'h38);
    chkNt("R9");
    chkSlots("R7");
    for (int j = 0; j < 4; j++) begin
      doWrite(16'hB004 | j, 0);
      chkNt("R9");                 // high 0 but low != j: still ROM
      doWrite(16'hB000 | j, j);
      chkNt("R9");                 // identity: cancelled
      doWrite(16'hB004 | j, 1);
      chkNt("R9");                 // high nonzero: ROM again
    end
    doWrite(16'hD000, 8'h18);
    chkNt("R9");

    // R10 ignored writes and idle cycles
    doWrite(16'h8000, 8'hAA);
    doWrite(16'hC005, 8'h55);
    doWrite(16'hD002, 8'hFF);
    doWrite(16'hD003, 8'hFF);
    doWrite(16'hE000, 8'h3F);
    chkSlots("R10");
    chkNt("R10");
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 16'h9000; wrData = 8'hEE;
    @(negedge clk);
    wrAddr = 16'hD000; wrData = 8'h20;
    @(negedge clk);
    chkSlots("R10");
    chkNt("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule